// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave-only I2C endpoint that gives an external bus master byte access to a simple 8-bit register file. It runs entirely on a fast system clock. SCL and SDA pass through two-flop synchronizers, and the block finds bus edges and START/STOP conditions by comparing successive samples. It never drives SDA high. It asserts an open-drain enable that pulls the line low, and a pull-up returns the line high when the enable is released.

The 7-bit device address is a fixed prefix `00110` followed by two strap inputs, which gives addresses 0x18 to 0x1B. The block also answers the general call address (address byte 0x00) and treats it as a write. A write transaction loads an internal register pointer from its first data byte. Every later data byte goes to the pointed register, and the pointer then advances. A read transaction starts at the current pointer and returns consecutive registers for as long as the master acknowledges. The pointer is eight bits wide, wraps from 0xFF to 0x00, and keeps its value from one transaction to the next.

Top module: `i2c_reg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `0011 0` followed by strap_i[1] and strap_i[0] is acknowledged. The slave holds SDA low through the ninth SCL clock. Bytes go MSB first, and bit 0 of the address byte is the direction, with 1 meaning read.
- R2: The address byte 0x00 (general call) is acknowledged and handled as a write. The address byte 0x01 is not acknowledged.
- R3: Any other address byte gets no acknowledge. Until the next START the slave then writes no register and never pulls SDA low.
- R4: In a write, the first data byte after the address sets the register pointer. It is acknowledged and causes no register write.
- R5: Each further write data byte is acknowledged and produces exactly one single-cycle reg_we strobe with reg_addr equal to the pointer. The pointer then advances by one and wraps from 0xFF to 0x00.
- R6: A read sends the register at the current pointer, MSB first, starting on the SCL low phase after the address acknowledge.
- R7: After each byte sent, the pointer advances. A master acknowledge makes the slave send the next register. A master not-acknowledge makes the slave release SDA and leave the bus alone until the next START.
- R8: A START seen during an active transaction restarts address reception at once. The slave releases SDA on every START.
- R9: sda_oe is low after reset. It changes only while SCL is low.
- R10: A STOP returns the slave to idle with SDA released. The pointer keeps its value into the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 2 | Low two bits of the 7-bit device address |
| reg_addr | output | AW (8) | Register file address (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register file read data for reg_addr |

## Verification
Address decoding is swept over every strap setting against the general call, the four strapped addresses and the neighbouring non-matching addresses. This separates the prefix compare from the strap compare and from the general call case. Writes are tried with one data byte and with a run across 0xFF, which separates pointer loading from register writing and shows the wrap. Reads are tried after a repeated START, as a continuation after STOP, and across the wrap. These cases separate the master acknowledge from the not-acknowledge and show that the pointer survives a STOP. A bus monitor confirms that SDA is never moved while SCL is high.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  localparam logic [4:0] ADDR_PREFIX = 5'b00110;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDATA,
    S_DACK,
    S_TX,
    S_MACK,
    S_IGNORE
  } slv_state_t;

  // Address byte accepted: strapped address (either direction) or general call write.
  function automatic logic addr_hit(input logic [7:0] abyte, input logic [1:0] strap);
    return (abyte == 8'h00) || (abyte[7:1] == {ADDR_PREFIX, strap});
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_evt =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_evt  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_slv_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [1:0]    strap,
  input  logic [7:0]    reg_rdata,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wdata,
  output logic          we,
  output logic          oe
);

  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  slv_state_t    state;
  logic [CW-1:0] cnt;
  logic [7:0]    rx_sr;
  logic [7:0]    tx_sr;
  logic          rw;
  logic          ptr_pending;
  logic          mack;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      rw          <= 1'b0;
      ptr_pending <= 1'b0;
      mack        <= 1'b0;
      ptr         <= '0;
      wdata       <= '0;
      we          <= 1'b0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr_next(ptr);
      if (start_evt) begin
        state <= S_ADDR;
        cnt   <= '0;
      end else if (stop_evt) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_WDATA: begin
            if (scl_rise && cnt != LAST) begin
              rx_sr <= {rx_sr[6:0], sda_s};
              cnt   <= cnt + CW'(1);
            end else if (scl_fall && cnt == LAST) begin
              if (state == S_ADDR) begin
                if (addr_hit(rx_sr, strap)) begin
                  state       <= S_AACK;
                  rw          <= rx_sr[0];
                  ptr_pending <= ~rx_sr[0];
                end else begin
                  state <= S_IGNORE;
                end
              end else begin
                state <= S_DACK;
                if (ptr_pending) begin
                  ptr         <= AW'(rx_sr);
                  ptr_pending <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  wdata <= rx_sr;
                end
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx_sr <= reg_rdata;
                state <= S_TX;
              end else begin
                state <= S_WDATA;
              end
            end
          end
          S_DACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= S_WDATA;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                state <= S_MACK;
                mack  <= 1'b0;
                ptr   <= ptr_next(ptr);
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sr <= reg_rdata;
                cnt   <= '0;
                state <= S_TX;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_AACK, S_DACK: oe = 1'b1;
      S_TX:           oe = ~tx_sr[7];
      default:        oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    strap_i,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_slave_core #(.AW(AW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap     (strap_i),
    .reg_rdata (reg_rdata),
    .ptr       (reg_addr),
    .wdata     (reg_wdata),
    .we        (reg_we),
    .oe        (sda_oe)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_evt,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == AW'($past(reg_addr) + AW'(1))));

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr)
);

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [0:255];
  int         wcount = 0;
  int         checks = 0;
  int         failures = 0;
  int         oe_viol = 0;
  logic       oe_prev = 1'b0;
  wire        sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_reg_slave u_i2c_reg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .strap_i   (strap),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wcount <= wcount + 1;
    end
  end

  // R9 monitor: the pull-down enable must not move while the raw SCL line is high
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe != oe_prev)) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    ack = ~sda_line;
    wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      scl_m = 1'b1; wq(1);
      b[i] = sda_line;
      wq(1);
      scl_m = 1'b0;
    end
    wq(1);
    sda_m = give_ack ? 1'b0 : 1'b1; wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit         ack;
    logic [7:0] rb;
    int         w0;
    logic [7:0] base;

    repeat (5) @(negedge clk);
    // R9 reset state
    check(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    check(reg_we == 1'b0, "R5 reset reg_we", reg_we, 0);
    rst_n = 1'b1;
    wq(2);

    // R1 R2 R3 R4 R5: sweep straps against candidate addresses
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      wq(1);
      for (int k = 0; k < 9; k++) begin
        int  a;
        bit  exp;
        logic [7:0] p, d;
        a   = (k == 0) ? 0 : (16'h16 + k - 1);
        exp = (a == 0) || (((a >> 2) == 6) && ((a & 3) == s));
        w0  = wcount;
        bus_start();
        send_byte(8'(a << 1), ack);
        check(ack == exp, (a == 0) ? "R2 general call ack" : (exp ? "R1 address ack" : "R3 address nack"), ack, exp);
        if (exp) begin
          p = 8'(8'h80 + s * 16 + k);
          d = 8'(a ^ 8'h3C ^ (s * 5));
          send_byte(p, ack);
          check(ack && (wcount == w0), "R4 pointer byte ack, no write", wcount - w0, 0);
          send_byte(d, ack);
          wq(1);
          check(ack && (mem[p] == d), "R5 data written at pointer", mem[p], d);
          check(wcount == w0 + 1, "R5 single write strobe", wcount - w0, 1);
        end else begin
          send_byte(8'hA5, ack);
          wq(1);
          check(!ack && (wcount == w0), "R3 ignored after nack", wcount - w0, 0);
        end
        bus_stop();
        check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
      end
    end

    // R5 pointer wrap on writes
    strap = 2'd2;
    wq(1);
    w0 = wcount;
    bus_start();
    send_byte(8'h1A << 1, ack);
    send_byte(8'hFD, ack);
    for (int i = 0; i < 4; i++) send_byte(8'(8'hC0 + i), ack);
    bus_stop();
    check(wcount == w0 + 4, "R5 four writes", wcount - w0, 4);
    for (int i = 0; i < 4; i++)
      check(mem[8'(8'hFD + i)] == 8'(8'hC0 + i), "R5 wrap write", mem[8'(8'hFD + i)], 8'hC0 + i);

    // R8 R6 R7: pointer set, repeated START, multi-byte read
    bus_start();
    send_byte(8'h1A << 1, ack);
    send_byte(8'h10, ack);
    bus_start();
    send_byte((8'h1A << 1) | 8'h01, ack);
    check(ack, "R8 read address ack after repeated start", ack, 1);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i != 4, rb);
      check(rb == mem[8'(8'h10 + i)], "R6 read byte", rb, mem[8'(8'h10 + i)]);
    end
    wq(1);
    check(sda_oe == 1'b0, "R7 released after master nack", sda_oe, 0);
    send_byte(8'h00, ack);
    check(!ack, "R7 bus ignored after nack", ack, 0);
    bus_stop();

    // R10 R7: pointer carried across STOP
    bus_start();
    send_byte((8'h1A << 1) | 8'h01, ack);
    recv_byte(1'b0, rb);
    bus_stop();
    check(rb == mem[8'h15], "R10 pointer retained", rb, mem[8'h15]);

    // R7 read wrap 0xFE, 0xFF, 0x00
    base = 8'hFE;
    bus_start();
    send_byte(8'h1A << 1, ack);
    send_byte(base, ack);
    bus_stop();
    bus_start();
    send_byte((8'h1A << 1) | 8'h01, ack);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, rb);
      check(rb == mem[8'(base + i)], "R7 read wrap", rb, mem[8'(base + i)]);
    end
    bus_stop();

    // R2 general call read not acknowledged
    bus_start();
    send_byte(8'h01, ack);
    bus_stop();
    check(!ack, "R2 address 0x01 nack", ack, 0);

    // R2 general call write path
    w0 = wcount;
    bus_start();
    send_byte(8'h00, ack);
    send_byte(8'h40, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    check(mem[8'h40] == 8'h5A && wcount == w0 + 1, "R2 general call write", mem[8'h40], 8'h5A);

    check(oe_viol == 0, "R9 sda_oe moved with SCL high", oe_viol, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule